// File: doc/BRIEF.md
# Vector Register Pair Store Unit

This unit turns one 32-bit instruction word into a single memory write request. The instruction stores two floating-point/vector registers side by side and carries a non-temporal hint. The unit decodes the word and reads the two data registers and the base register through combinational read ports. It then forms the effective address from the base and a scaled signed offset and packs the pair onto a 256-bit bus. The request comes out of one register stage one clock later.

The size field selects 32-, 64- or 128-bit elements. The pair therefore covers 8, 16 or 32 bytes. The data is right-aligned on the bus and the byte enables mark the valid bytes. Base index 31 selects the stack pointer. That access is not tag-checked and may fault on misalignment. A word that is not this instruction raises a one-cycle undefined flag instead of a request.

Top module: `stp_nt_unit`

## Requirements
- R1: An instruction is legal when bits [29:22] equal 8'b10110000 and the size field in bits [31:30] is 0, 1 or 2. Any other word, including size 3, yields no request and pulses `evt_undef` high for exactly the cycle after acceptance.
- R2: For size field s, `req_bytes` is 8<<s (8, 16 or 32). `req_be` has exactly its lowest `req_bytes` bits set.
- R3: `req_addr` equals the base plus the 7-bit offset field [21:15]. The offset is sign-extended and shifted left by 2+s, and the sum wraps modulo 2^64.
- R4: `gpr_raddr` carries bits [9:5]. When that index is 31 the base is `sp_value`, otherwise it is `gpr_rdata`. `req_tagchk` is 1 exactly when the index is not 31.
- R5: When the base index is 31, `sp_check_en` is high and `sp_value[3:0]` is nonzero, no request is made and `evt_sp_fault` pulses for the cycle after acceptance. An undefined word never raises `evt_sp_fault`.
- R6: Port A reads index [4:0] and port B reads index [14:10]. With `big_endian` low, the lowest w=32<<s data bits hold port A's low w bits and the next w bits hold port B's low w bits. All higher bus bits are zero.
- R7: With `big_endian` high, the two halves of R6 are swapped: port B's element sits in the low half and port A's in the high half.
- R8: `req_nontemporal` is 1 on every request.
- R9: `in_ready` is high when the output is empty or drained in the same cycle. An accepted legal word shows its request on the next cycle whatever the data values. A stalled request keeps all its fields stable.
- R10: After reset `req_valid`, `evt_undef` and `evt_sp_fault` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Instruction word can be taken |
| in_instr | input | 32 | Instruction word |
| big_endian | input | 1 | Data ordering mode for this word |
| sp_check_en | input | 1 | Enables the stack pointer alignment check |
| sp_value | input | 64 | Current stack pointer |
| gpr_raddr | output | 5 | Base register read index |
| gpr_rdata | input | 64 | Base register read data |
| vr_raddr_a | output | 5 | First data register read index |
| vr_rdata_a | input | 128 | First data register read data |
| vr_raddr_b | output | 5 | Second data register read index |
| vr_rdata_b | input | 128 | Second data register read data |
| req_valid | output | 1 | Store request present |
| req_ready | input | 1 | Store request taken by memory side |
| req_addr | output | 64 | Effective byte address |
| req_bytes | output | 6 | Byte count of the store |
| req_data | output | 256 | Right-aligned store data |
| req_be | output | 32 | Byte enables |
| req_nontemporal | output | 1 | Non-temporal hint |
| req_tagchk | output | 1 | Access is tag-checked |
| evt_undef | output | 1 | Undefined instruction pulse |
| evt_sp_fault | output | 1 | Stack pointer alignment fault pulse |

## Verification
Two events can fall in the same cycle. The first is the draining of a held request and the acceptance of a new word. The bench provokes it by stalling `req_ready` with a second word pending and then raising ready. It judges that the second request's address appears on the very next cycle and that the output never goes empty. The second overlap is an undefined size code combined with a misaligned stack-pointer base. The sweep covers it, and the bench expects only `evt_undef` and no request.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam logic [7:0] FIXED_PATTERN = 8'b10110000;
  localparam logic [IDX_W-1:0] SP_INDEX = 5'd31;

  typedef struct packed {
    logic [1:0]       size;
    logic [6:0]       imm;
    logic [IDX_W-1:0] rb;
    logic [IDX_W-1:0] rbase;
    logic [IDX_W-1:0] ra;
    logic             undef;
  } dec_t;
endpackage

// File: rtl/stp_decode.sv
module stp_decode
  import stp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic fixed_ok;
  logic size_ok;

  always_comb begin
    fixed_ok    = (instr[29:22] == FIXED_PATTERN);
    size_ok     = (instr[31:30] != 2'b11);
    dec.size    = instr[31:30];
    dec.imm     = instr[21:15];
    dec.rb      = instr[14:10];
    dec.rbase   = instr[9:5];
    dec.ra      = instr[4:0];
    dec.undef   = !(fixed_ok && size_ok);
  end
endmodule

// File: rtl/stp_addr_gen.sv
module stp_addr_gen
  import stp_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int ALIGN_B = 16
) (
  input  logic [IDX_W-1:0]  rbase,
  input  logic [6:0]        imm,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] gpr_val,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic              check_en,
  output logic [ADDR_W-1:0] addr,
  output logic              tagchk,
  output logic              misaligned
);
  localparam int ALIGN_BITS = $clog2(ALIGN_B);

  logic              use_sp;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs_ext;
  logic [ADDR_W-1:0] offs;
  logic [2:0]        shamt;

  always_comb begin
    use_sp     = (rbase == SP_INDEX);
    base       = use_sp ? sp_val : gpr_val;
    offs_ext   = {{(ADDR_W-7){imm[6]}}, imm};
    shamt      = 3'd2 + {1'b0, size};
    offs       = offs_ext << shamt;
    addr       = base + offs;
    tagchk     = !use_sp;
    misaligned = use_sp && check_en && (sp_val[ALIGN_BITS-1:0] != '0);
  end
endmodule

// File: rtl/stp_data_pack.sv
module stp_data_pack #(
  parameter int VREG_W = 128,
  parameter int BUS_W  = 2 * VREG_W,
  parameter int CNT_W  = $clog2(BUS_W / 8) + 1
) (
  input  logic [VREG_W-1:0] elem_a,
  input  logic [VREG_W-1:0] elem_b,
  input  logic [1:0]        size,
  input  logic              swap,
  output logic [BUS_W-1:0]  data,
  output logic [BUS_W/8-1:0] be,
  output logic [CNT_W-1:0]  nbytes
);
  localparam int BUS_B  = BUS_W / 8;
  localparam int NSIZES = 3;

  logic [VREG_W-1:0] first;
  logic [VREG_W-1:0] second;
  logic [BUS_W-1:0]  cand_data [NSIZES];
  logic [BUS_B-1:0]  cand_be   [NSIZES];
  logic [CNT_W-1:0]  cand_cnt  [NSIZES];

  assign first  = swap ? elem_b : elem_a;
  assign second = swap ? elem_a : elem_b;

  for (genvar k = 0; k < NSIZES; k++) begin : g_size
    localparam int W  = VREG_W >> (NSIZES - 1 - k);
    localparam int PB = (2 * W) / 8;
    assign cand_data[k] = ({{(BUS_W-W){1'b0}}, second[W-1:0]} << W)
                        | {{(BUS_W-W){1'b0}}, first[W-1:0]};
    assign cand_be[k]   = {BUS_B{1'b1}} >> (BUS_B - PB);
    assign cand_cnt[k]  = CNT_W'(PB);
  end

  always_comb begin
    case (size)
      2'd0: begin data = cand_data[0]; be = cand_be[0]; nbytes = cand_cnt[0]; end
      2'd1: begin data = cand_data[1]; be = cand_be[1]; nbytes = cand_cnt[1]; end
      2'd2: begin data = cand_data[2]; be = cand_be[2]; nbytes = cand_cnt[2]; end
      default: begin data = '0; be = '0; nbytes = '0; end
    endcase
  end
endmodule

// File: rtl/stp_nt_unit.sv
module stp_nt_unit
  import stp_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VREG_W  = 128,
  parameter int ALIGN_B = 16,
  parameter int BUS_W   = 2 * VREG_W,
  parameter int BUS_B   = BUS_W / 8,
  parameter int CNT_W   = $clog2(BUS_B) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  input  logic              big_endian,
  input  logic              sp_check_en,
  input  logic [ADDR_W-1:0] sp_value,
  output logic [4:0]        gpr_raddr,
  input  logic [ADDR_W-1:0] gpr_rdata,
  output logic [4:0]        vr_raddr_a,
  input  logic [VREG_W-1:0] vr_rdata_a,
  output logic [4:0]        vr_raddr_b,
  input  logic [VREG_W-1:0] vr_rdata_b,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CNT_W-1:0]  req_bytes,
  output logic [BUS_W-1:0]  req_data,
  output logic [BUS_B-1:0]  req_be,
  output logic              req_nontemporal,
  output logic              req_tagchk,
  output logic              evt_undef,
  output logic              evt_sp_fault
);
  dec_t              dec;
  logic [ADDR_W-1:0] addr_c;
  logic              tag_c;
  logic              misal_c;
  logic [BUS_W-1:0]  data_c;
  logic [BUS_B-1:0]  be_c;
  logic [CNT_W-1:0]  cnt_c;
  logic              accept;
  logic              issue;

  stp_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  assign gpr_raddr  = dec.rbase;
  assign vr_raddr_a = dec.ra;
  assign vr_raddr_b = dec.rb;

  stp_addr_gen #(.ADDR_W(ADDR_W), .ALIGN_B(ALIGN_B)) u_addr (
    .rbase      (dec.rbase),
    .imm        (dec.imm),
    .size       (dec.size),
    .gpr_val    (gpr_rdata),
    .sp_val     (sp_value),
    .check_en   (sp_check_en),
    .addr       (addr_c),
    .tagchk     (tag_c),
    .misaligned (misal_c)
  );

  stp_data_pack #(.VREG_W(VREG_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_pack (
    .elem_a (vr_rdata_a),
    .elem_b (vr_rdata_b),
    .size   (dec.size),
    .swap   (big_endian),
    .data   (data_c),
    .be     (be_c),
    .nbytes (cnt_c)
  );

  assign in_ready = !req_valid || req_ready;
  assign accept   = in_valid && in_ready;
  assign issue    = accept && !dec.undef && !misal_c;

  // control path: reset
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid    <= 1'b0;
      evt_undef    <= 1'b0;
      evt_sp_fault <= 1'b0;
    end else begin
      evt_undef    <= accept && dec.undef;
      evt_sp_fault <= accept && !dec.undef && misal_c;
      if (accept)         req_valid <= issue;
      else if (req_ready) req_valid <= 1'b0;
    end
  end

  // data path: load-enabled, no reset
  always_ff @(posedge clk) begin
    if (issue) begin
      req_addr        <= addr_c;
      req_bytes       <= cnt_c;
      req_data        <= data_c;
      req_be          <= be_c;
      req_tagchk      <= tag_c;
      req_nontemporal <= 1'b1;
    end
  end
endmodule

// File: rtl/stp_nt_unit_chk.sv
module stp_nt_unit_chk #(
  parameter int ADDR_W = 64,
  parameter int BUS_W  = 256,
  parameter int BUS_B  = 32,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [CNT_W-1:0]  req_bytes,
  input logic [BUS_W-1:0]  req_data,
  input logic [BUS_B-1:0]  req_be,
  input logic              req_nontemporal,
  input logic              evt_undef,
  input logic              evt_sp_fault
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_be)); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |-> !in_ready); // R9

  AST_ROSE_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> $past(in_valid && in_ready)); // R9

  AST_BYTES_LEGAL: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_bytes == 6'd8 || req_bytes == 6'd16 || req_bytes == 6'd32)); // R2

  AST_BE_COUNT: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ($countones(req_be) == int'(req_bytes))); // R2

  AST_NT_SET: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_nontemporal); // R8

  AST_UNDEF_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    evt_undef |-> !req_valid); // R1

  AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    evt_sp_fault |-> !req_valid); // R5

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_undef, evt_sp_fault})); // R5

  for (genvar i = 0; i < BUS_B; i++) begin : g_byte
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      req_valid && !req_be[i] |-> req_data[8*i +: 8] == 8'h00); // R6
  end
endmodule

bind stp_nt_unit stp_nt_unit_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .BUS_B(BUS_B), .CNT_W(CNT_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_addr        (req_addr),
  .req_bytes       (req_bytes),
  .req_data        (req_data),
  .req_be          (req_be),
  .req_nontemporal (req_nontemporal),
  .evt_undef       (evt_undef),
  .evt_sp_fault    (evt_sp_fault)
);

// File: tb/sim_stp_nt_unit.sv
module sim_stp_nt_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_instr = '0;
  logic         big_endian = 1'b0;
  logic         sp_check_en = 1'b0;
  logic [63:0]  sp_value = '0;
  logic [4:0]   gpr_raddr;
  logic [63:0]  gpr_rdata;
  logic [4:0]   vr_raddr_a;
  logic [127:0] vr_rdata_a;
  logic [4:0]   vr_raddr_b;
  logic [127:0] vr_rdata_b;
  logic         req_valid;
  logic         req_ready = 1'b1;
  logic [63:0]  req_addr;
  logic [5:0]   req_bytes;
  logic [255:0] req_data;
  logic [31:0]  req_be;
  logic         req_nontemporal;
  logic         req_tagchk;
  logic         evt_undef;
  logic         evt_sp_fault;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  function automatic logic [127:0] vreg(input logic [4:0] i);
    logic [127:0] v;
    for (int j = 0; j < 4; j++) v[32*j +: 32] = 32'hA500_0000 | (32'(i) << 8) | 32'(j + 1);
    return v;
  endfunction

  function automatic logic [63:0] greg(input logic [4:0] i);
    return 64'hFFFF_FFFF_FFFF_FF00 + 64'(i) * 64'd16;
  endfunction

  assign vr_rdata_a = vreg(vr_raddr_a);
  assign vr_rdata_b = vreg(vr_raddr_b);
  assign gpr_rdata  = greg(gpr_raddr);

  stp_nt_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] s, input logic [6:0] imm,
                                     input logic [4:0] b, input logic [4:0] n, input logic [4:0] a);
    return {s, 8'b10110000, imm, b, n, a};
  endfunction

  task automatic send(input logic [31:0] w, input bit be_mode, input bit ce, input logic [63:0] sp);
    logic [1:0]   s;
    logic [4:0]   a, b, n;
    logic [63:0]  base, offs, ea;
    int           wd, nb;
    logic [255:0] lo, hi, dexp, mask;
    bit           legal, fault;
    s = w[31:30]; a = w[4:0]; b = w[14:10]; n = w[9:5];
    legal = (w[29:22] == 8'b10110000) && (s != 2'b11);
    fault = legal && (n == 5'd31) && ce && (sp[3:0] != 4'h0);
    @(negedge clk);
    in_instr = w; big_endian = be_mode; sp_check_en = ce; sp_value = sp; in_valid = 1'b1;
    #0.5;
    chk(gpr_raddr == n && vr_raddr_a == a && vr_raddr_b == b, "R4/R6 read indices",
        {gpr_raddr, vr_raddr_a, vr_raddr_b}, {n, a, b});
    @(negedge clk);
    in_valid = 1'b0;
    chk(evt_undef == !legal, "R1 undef pulse", evt_undef, !legal);
    chk(evt_sp_fault == fault, "R5 sp fault pulse", evt_sp_fault, fault);
    chk(req_valid == (legal && !fault), "R9 one-cycle request", req_valid, legal && !fault);
    if (legal && !fault) begin
      base = (n == 5'd31) ? sp : greg(n);
      offs = 64'(signed'(w[21:15])) * (64'd4 << s);
      ea   = base + offs;
      wd   = 32 << s;
      nb   = 2 * wd / 8;
      mask = (256'd1 << wd) - 256'd1;
      lo   = 256'(vreg(be_mode ? b : a)) & mask;
      hi   = 256'(vreg(be_mode ? a : b)) & mask;
      dexp = (hi << wd) | lo;
      chk(req_addr == ea, "R3 address", req_addr, ea);
      chk(req_bytes == 6'(nb), "R2 byte count", req_bytes, nb);
      chk(req_be == 32'((64'd1 << nb) - 64'd1), "R2 byte enables", req_be, (64'd1 << nb) - 64'd1);
      chk(req_data == dexp, be_mode ? "R7 big-endian data" : "R6 little-endian data", req_data, dexp);
      chk(req_tagchk == (n != 5'd31), "R4 tag check", req_tagchk, n != 5'd31);
      chk(req_nontemporal == 1'b1, "R8 non-temporal", req_nontemporal, 1'b1);
    end
    @(negedge clk);
    chk(!evt_undef && !evt_sp_fault, "R1 R5 pulse width", {evt_undef, evt_sp_fault}, 2'b00);
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] imms [6];
    logic [31:0] w1, w2;
    logic [63:0] e1, e2;
    imms = '{7'd0, 7'd1, 7'd63, 7'd64, 7'd127, 7'h2a};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!req_valid && !evt_undef && !evt_sp_fault && in_ready, "R10 reset state",
        {req_valid, evt_undef, evt_sp_fault, in_ready}, 4'b0001);

    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++)
        for (int k = 0; k < 6; k++)
          for (int r = 0; r < 2; r++)
            for (int c = 0; c < 2; c++) begin
              logic [4:0] n;
              n = (r == 0) ? 5'd3 : 5'd31;
              send(mk(2'(s), imms[k], 5'((k * 11 + 5) % 32), n, 5'((k * 7 + s) % 32)),
                   e[0], c[0], (c == 1 && k[0]) ? 64'h0000_0000_0000_1008 : 64'h0000_0000_0000_2000);
            end

    for (int bit_i = 22; bit_i < 30; bit_i++) begin
      logic [31:0] w;
      w = mk(2'd1, 7'd5, 5'd2, 5'd4, 5'd6);
      w[bit_i] = ~w[bit_i];
      send(w, 1'b0, 1'b0, 64'h0);
    end

    // stall with a second word pending, then drain and accept together
    w1 = mk(2'd2, 7'd2, 5'd9, 5'd1, 5'd8);
    w2 = mk(2'd0, 7'h7f, 5'd10, 5'd2, 5'd11);
    e1 = greg(5'd1) + 64'd32;
    e2 = greg(5'd2) - 64'd4;
    @(negedge clk);
    req_ready = 1'b0;
    in_instr = w1; big_endian = 1'b0; sp_check_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_instr = w2;
    #0.5;
    chk(!in_ready, "R9 ready low while stalled", in_ready, 1'b0);
    @(negedge clk);
    chk(req_valid && req_addr == e1, "R9 held request", req_addr, e1);
    req_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req_valid && req_addr == e2, "R9 back-to-back", req_addr, e2);
    @(negedge clk);
    chk(!req_valid, "R9 drained", req_valid, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule